// File: doc/BRIEF.md
# Protected receive frame buffer

This block holds a single received frame between a receive datapath and a host read port. The datapath marks a frame with a start pulse, delivers bytes with a valid strobe and closes the frame with an end pulse. The end pulse carries a check-valid flag, an end-of-frame interrupt flag, an energy level and a status byte. The first byte after the start pulse is the frame length; the bytes after it are payload. The host opens a read access, then pops bytes one at a time. It sees the length, the payload, the energy level and the status byte, in that order.

A completed frame can be locked against overwriting. In basic mode the lock is set by a valid check sequence. In extended mode it is set by the end-of-frame interrupt flag. While the lock is held, any frame that starts is discarded whole and counted. The lock is released one cycle after the host ends its read access. The host may also read a frame while it is still arriving. An empty flag then tells it that the byte under its read pointer has not been written yet.

Top module: `rxfb_guard`

## Requirements
- R1: Without the lock, a frame that starts replaces the stored frame: a following read returns only the new frame's bytes.
- R2: With `ext_mode`=0, a frame is locked at its end pulse if `rx_crc_ok` is 1. A frame ending with `rx_crc_ok`=0 is not locked.
- R3: With `ext_mode`=1, a frame is locked at its end pulse if `rx_irq_end` is 1. `rx_crc_ok` has no effect on locking in this mode.
- R4: A start pulse seen while the lock is held discards that frame whole. The stored frame is left unchanged, and `drop_count` rises by one on the next cycle.
- R5: The lock clears on the clock edge after `rd_active` is first sampled low. A start pulse in the first low cycle is still discarded. A start pulse one cycle later is accepted.
- R6: During a read access, read position 0 returns the length. Positions 1..L return the payload bytes in arrival order. Position L+1 returns the energy byte, position L+2 returns the status byte, and later positions return 0. `rd_data` shows the byte at the current position, and each cycle with `rd_req` high moves to the next position.
- R7: While `rd_active` is low the read position is 0, so every read access starts with the length byte.
- R8: `rd_empty` is 1 when `rd_active` is 1, a frame is still arriving, and the read position is not yet written. Pops are ignored while `rd_empty` is 1.
- R9: `rd_empty` is 0 whenever `rd_active` is 0.
- R10: The length is the low 7 bits of the first byte, limited to `MAX_LEN` (127). Payload bytes beyond that length are ignored.
- R11: After reset the buffer is unlocked, `drop_count` is 0, `rd_empty` is 0 and the length byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 0: lock on valid check sequence; 1: lock on end-of-frame interrupt |
| rx_start | input | 1 | Frame start pulse (carries no data) |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte (first one is the length) |
| rx_end | input | 1 | Frame end pulse |
| rx_crc_ok | input | 1 | Check sequence valid, sampled with rx_end |
| rx_irq_end | input | 1 | End-of-frame interrupt raised, sampled with rx_end |
| rx_ed | input | 8 | Energy level, captured at rx_end |
| rx_status | input | 8 | Receive status, captured at rx_end |
| rd_active | input | 1 | Host read access in progress |
| rd_req | input | 1 | Advance to the next read position |
| rd_data | output | 8 | Byte at the current read position |
| rd_empty | output | 1 | Read position not yet written |
| drop_count | output | DROP_W | Frames discarded because of the lock (wraps) |

## Verification
The hardest situation to reach is a host reading the frame while it is still arriving. Here the read pointer and the write fill level differ by at most one byte, and the bench must check both that the empty flag is raised and that pops are ignored while it is. The bench reaches this by opening a read access right after a start pulse. It then alternates single receive bytes with single pops, checking the flag and the data after every step, and closes the frame while the pointer sits on the energy slot. A second hard case is the single-cycle release edge. The bench drives a start pulse in the very cycle the read access drops, then another one cycle later, to show the first is discarded and the second accepted.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

    typedef logic [7:0] byte_t;

    // Which field the host read position currently selects
    typedef enum logic [2:0] {
        SLOT_LEN  = 3'd0,
        SLOT_PAY  = 3'd1,
        SLOT_ED   = 3'd2,
        SLOT_ST   = 3'd3,
        SLOT_NONE = 3'd4
    } rd_slot_e;

endpackage

// File: rtl/rxfb_store.sv
module rxfb_store
    import rxfb_pkg::*;
#(
    parameter int DEPTH = 127,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);

    byte_t mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        byte_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && waddr == AW'(i)) ent_d = wdata;
        end

        always_ff @(posedge clk) begin
            ent_q <= ent_d;
        end

        assign mem_q[i] = ent_q;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxfb_rdmux.sv
module rxfb_rdmux
    import rxfb_pkg::*;
#(
    parameter int LEN_W = 7,
    parameter int PTR_W = 8,
    parameter int AW    = 7
) (
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [LEN_W-1:0] len,
    input  byte_t            ed,
    input  byte_t            st,
    input  byte_t            mem_rdata,
    output logic [AW-1:0]    raddr,
    output byte_t            rd_data
);

    logic [PTR_W-1:0] len_x;
    rd_slot_e         slot;

    assign len_x = PTR_W'(len);

    always_comb begin
        raddr = '0;
        if (rd_ptr == '0) begin
            slot = SLOT_LEN;
        end else if (rd_ptr <= len_x) begin
            slot  = SLOT_PAY;
            raddr = AW'(rd_ptr - PTR_W'(1));
        end else if (rd_ptr == len_x + PTR_W'(1)) begin
            slot = SLOT_ED;
        end else if (rd_ptr == len_x + PTR_W'(2)) begin
            slot = SLOT_ST;
        end else begin
            slot = SLOT_NONE;
        end
    end

    always_comb begin
        case (slot)
            SLOT_LEN: rd_data = 8'(len);
            SLOT_PAY: rd_data = mem_rdata;
            SLOT_ED:  rd_data = ed;
            SLOT_ST:  rd_data = st;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rxfb_ctrl.sv
module rxfb_ctrl
    import rxfb_pkg::*;
#(
    parameter int MAX_LEN = 127,
    parameter int LEN_W   = 7,
    parameter int PTR_W   = 8,
    parameter int AW      = 7,
    parameter int DROP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  byte_t             rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_ok,
    input  logic              rx_irq_end,
    input  byte_t             rx_ed,
    input  byte_t             rx_status,
    input  logic              rd_active,
    input  logic              rd_req,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output byte_t             wdata,
    output logic [LEN_W-1:0]  len_q,
    output byte_t             ed_q,
    output byte_t             st_q,
    output logic [PTR_W-1:0]  rd_ptr_q,
    output logic              wr_act_q,
    output logic              prot_q,
    output logic [DROP_W-1:0] drop_q,
    output logic              rd_empty
);

    typedef struct packed {
        logic              prot;
        logic              wr_act;
        logic              rd_prev;
        logic [PTR_W-1:0]  fill;
        logic [PTR_W-1:0]  rd_ptr;
        logic [LEN_W-1:0]  len;
        byte_t             ed;
        byte_t             st;
        logic [DROP_W-1:0] drops;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic [LEN_W-1:0] hdr_len;
    logic             lock_hit;
    logic             empty;

    // Length field from the first byte, limited to the buffer size
    always_comb begin
        hdr_len = rx_data[LEN_W-1:0];
        if (hdr_len > LEN_W'(MAX_LEN)) hdr_len = LEN_W'(MAX_LEN);
    end

    assign lock_hit = ext_mode ? rx_irq_end : rx_crc_ok;
    assign empty    = rd_active && s_q.wr_act && (s_q.rd_ptr >= s_q.fill);

    always_comb begin
        s_d   = s_q;
        we    = 1'b0;
        waddr = '0;
        wdata = rx_data;

        s_d.rd_prev = rd_active;

        // Release first so that a lock set in the same cycle wins
        if (s_q.rd_prev && !rd_active) s_d.prot = 1'b0;

        if (rx_start) begin
            if (s_q.prot) begin
                s_d.drops = s_q.drops + DROP_W'(1);
            end else begin
                s_d.wr_act = 1'b1;
                s_d.fill   = '0;
                s_d.len    = '0;
            end
        end else begin
            if (rx_valid && s_q.wr_act) begin
                if (s_q.fill == '0) begin
                    s_d.len  = hdr_len;
                    s_d.fill = PTR_W'(1);
                end else if (s_q.fill <= PTR_W'(s_q.len)) begin
                    we       = 1'b1;
                    waddr    = AW'(s_q.fill - PTR_W'(1));
                    s_d.fill = s_q.fill + PTR_W'(1);
                end
            end
            if (rx_end && s_q.wr_act) begin
                s_d.wr_act = 1'b0;
                s_d.ed     = rx_ed;
                s_d.st     = rx_status;
                if (lock_hit) s_d.prot = 1'b1;
            end
        end

        if (!rd_active) begin
            s_d.rd_ptr = '0;
        end else if (rd_req && !empty && s_q.rd_ptr != '1) begin
            s_d.rd_ptr = s_q.rd_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign len_q    = s_q.len;
    assign ed_q     = s_q.ed;
    assign st_q     = s_q.st;
    assign rd_ptr_q = s_q.rd_ptr;
    assign wr_act_q = s_q.wr_act;
    assign prot_q   = s_q.prot;
    assign drop_q   = s_q.drops;
    assign rd_empty = empty;

endmodule

// File: rtl/rxfb_guard.sv
module rxfb_guard
    import rxfb_pkg::*;
#(
    parameter int MAX_LEN = 127,
    parameter int DROP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_ok,
    input  logic              rx_irq_end,
    input  logic [7:0]        rx_ed,
    input  logic [7:0]        rx_status,
    input  logic              rd_active,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    output logic              rd_empty,
    output logic [DROP_W-1:0] drop_count
);

    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int AW    = $clog2(MAX_LEN);
    localparam int PTR_W = $clog2(MAX_LEN + 3);

    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    byte_t             wr_byte;
    logic [AW-1:0]     rd_addr;
    byte_t             mem_rdata;
    logic [LEN_W-1:0]  len_q;
    byte_t             ed_q;
    byte_t             st_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic              wr_act_q;
    logic              prot_q;

    rxfb_ctrl #(
        .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .PTR_W(PTR_W), .AW(AW), .DROP_W(DROP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .rx_irq_end(rx_irq_end),
        .rx_ed(rx_ed), .rx_status(rx_status),
        .rd_active(rd_active), .rd_req(rd_req),
        .we(wr_en), .waddr(wr_addr), .wdata(wr_byte),
        .len_q(len_q), .ed_q(ed_q), .st_q(st_q), .rd_ptr_q(rd_ptr_q),
        .wr_act_q(wr_act_q), .prot_q(prot_q), .drop_q(drop_count),
        .rd_empty(rd_empty)
    );

    rxfb_store #(.DEPTH(MAX_LEN), .AW(AW)) u_store (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_byte),
        .raddr(rd_addr), .rdata(mem_rdata)
    );

    rxfb_rdmux #(.LEN_W(LEN_W), .PTR_W(PTR_W), .AW(AW)) u_rdmux (
        .rd_ptr(rd_ptr_q), .len(len_q), .ed(ed_q), .st(st_q),
        .mem_rdata(mem_rdata), .raddr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/rxfb_guard_chk.sv
module rxfb_guard_chk #(
    parameter int DROP_W = 8,
    parameter int PTR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_mode,
    input logic              rx_start,
    input logic              rx_end,
    input logic              rx_crc_ok,
    input logic              rx_irq_end,
    input logic              rd_active,
    input logic              rd_empty,
    input logic [DROP_W-1:0] drop_count,
    input logic              prot_q,
    input logic              wr_act_q,
    input logic              wr_en,
    input logic [PTR_W-1:0]  rd_ptr_q
);

    // R4: a start under lock is counted
    a_r4_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q && rx_start |=> drop_count == $past(drop_count) + DROP_W'(1));

    // R4: no buffer write while the lock is held
    a_r4_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q |-> !wr_en);

    // R2: basic mode locks on a valid check sequence
    a_r2_basic_lock: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act_q && rx_end && !rx_start && !ext_mode && rx_crc_ok |=> prot_q);

    // R3: extended mode locks on the end-of-frame interrupt
    a_r3_ext_lock: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act_q && rx_end && !rx_start && ext_mode && rx_irq_end |=> prot_q);

    // R5: lock cleared after the read access ends
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active && $past(rd_active) && !(wr_act_q && rx_end && !rx_start) |=> !prot_q);

    // R8: pointer holds while empty
    a_r8_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |=> rd_ptr_q == $past(rd_ptr_q));

    // R9: empty only inside a read access
    a_r9_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> !rd_empty);

endmodule

bind rxfb_guard rxfb_guard_chk #(.DROP_W(DROP_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .rx_start(rx_start),
    .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .rx_irq_end(rx_irq_end),
    .rd_active(rd_active), .rd_empty(rd_empty), .drop_count(drop_count),
    .prot_q(prot_q), .wr_act_q(wr_act_q), .wr_en(wr_en), .rd_ptr_q(rd_ptr_q)
);

// File: tb/rxfb_guard_tb.sv
module rxfb_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_mode, rx_start, rx_valid, rx_end, rx_crc_ok, rx_irq_end;
    logic [7:0] rx_data, rx_ed, rx_status;
    logic       rd_active, rd_req;
    logic [7:0] rd_data;
    logic       rd_empty;
    logic [7:0] drop_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rxfb_guard u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .rx_start(rx_start),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_crc_ok(rx_crc_ok), .rx_irq_end(rx_irq_end), .rx_ed(rx_ed),
        .rx_status(rx_status), .rd_active(rd_active), .rd_req(rd_req),
        .rd_data(rd_data), .rd_empty(rd_empty), .drop_count(drop_count)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] hdr, input int n_pay, input logic [7:0] base,
                              input logic crc, input logic irq,
                              input logic [7:0] ed, input logic [7:0] st);
        rx_start = 1'b1; tick; rx_start = 1'b0;
        rx_valid = 1'b1; rx_data = hdr; tick;
        for (int i = 0; i < n_pay; i++) begin
            rx_data = base + 8'(i); tick;
        end
        rx_valid = 1'b0;
        rx_end = 1'b1; rx_crc_ok = crc; rx_irq_end = irq; rx_ed = ed; rx_status = st;
        tick;
        rx_end = 1'b0; rx_crc_ok = 1'b0; rx_irq_end = 1'b0;
    endtask

    task automatic read_check(input string req, input int len, input logic [7:0] base,
                              input logic [7:0] ed, input logic [7:0] st, input bit finish);
        int exp;
        rd_active = 1'b1; rd_req = 1'b1;
        for (int p = 0; p <= len + 3; p++) begin
            if (p == 0)            exp = len;
            else if (p <= len)     exp = int'(base) + p - 1;
            else if (p == len + 1) exp = ed;
            else if (p == len + 2) exp = st;
            else                   exp = 0;
            #1 chk(req, rd_data, exp);
            tick;
        end
        rd_req = 1'b0;
        if (finish) begin
            rd_active = 1'b0; tick;
        end
    endtask

    task automatic t_reset;
        #1;
        chk("R11 empty", rd_empty, 0);
        chk("R11 drops", drop_count, 0);
        chk("R11 length", rd_data, 0);
        rd_active = 1'b1; #1;
        chk("R11 empty in read", rd_empty, 0);
        tick; rd_active = 1'b0; tick;
    endtask

    task automatic t_basic_overwrite;
        ext_mode = 1'b0;
        send_frame(8'd3, 3, 8'h10, 1'b0, 1'b0, 8'h01, 8'h02);
        send_frame(8'd4, 4, 8'h20, 1'b0, 1'b1, 8'h33, 8'h44);
        read_check("R1 overwrite", 4, 8'h20, 8'h33, 8'h44, 1'b1);
        send_frame(8'd2, 2, 8'h50, 1'b0, 1'b0, 8'h55, 8'h56);
        read_check("R2 bad check not locked", 2, 8'h50, 8'h55, 8'h56, 1'b1);
        chk("R2 no drops", drop_count, 0);
    endtask

    task automatic t_basic_lock;
        ext_mode = 1'b0;
        send_frame(8'd5, 5, 8'h60, 1'b1, 1'b0, 8'h71, 8'h72);
        send_frame(8'd3, 3, 8'h90, 1'b1, 1'b0, 8'h91, 8'h92);
        chk("R4 drop count", drop_count, 1);
        read_check("R4 R6 locked frame kept", 5, 8'h60, 8'h71, 8'h72, 1'b0);
        // start in the cycle rd_active drops: still locked
        rd_active = 1'b0; rx_start = 1'b1; tick;
        #1 chk("R5 start on release cycle dropped", drop_count, 2);
        send_frame(8'd2, 2, 8'hA0, 1'b0, 1'b0, 8'hA5, 8'hA6);
        chk("R5 next start accepted", drop_count, 2);
        read_check("R5 new frame", 2, 8'hA0, 8'hA5, 8'hA6, 1'b1);
    endtask

    task automatic t_ext;
        ext_mode = 1'b1;
        send_frame(8'd3, 3, 8'hB0, 1'b1, 1'b0, 8'hB5, 8'hB6);
        send_frame(8'd2, 2, 8'hC0, 1'b1, 1'b0, 8'hC5, 8'hC6);
        read_check("R3 check flag alone no lock", 2, 8'hC0, 8'hC5, 8'hC6, 1'b1);
        send_frame(8'd4, 4, 8'hD0, 1'b0, 1'b1, 8'hD5, 8'hD6);
        send_frame(8'd1, 1, 8'hF0, 1'b0, 1'b1, 8'hF5, 8'hF6);
        chk("R3 drop under ext lock", drop_count, 3);
        read_check("R3 locked by interrupt", 4, 8'hD0, 8'hD5, 8'hD6, 1'b1);
        ext_mode = 1'b0;
    endtask

    task automatic t_limit;
        send_frame(8'h85, 7, 8'hE0, 1'b0, 1'b0, 8'hE8, 8'hE9);
        read_check("R10 length field and excess bytes", 5, 8'hE0, 8'hE8, 8'hE9, 1'b1);
    endtask

    task automatic t_empty;
        rx_start = 1'b1; tick; rx_start = 1'b0;
        #1 chk("R9 empty idle while arriving", rd_empty, 0);
        rd_active = 1'b1; rd_req = 1'b1;
        #1 chk("R8 length not yet written", rd_empty, 1);
        tick;
        rd_req = 1'b0; rx_valid = 1'b1; rx_data = 8'd2; tick;
        rx_valid = 1'b0;
        #1 chk("R8 pop ignored, length ready", rd_empty, 0);
        chk("R8 length byte", rd_data, 2);
        rd_req = 1'b1; tick;
        #1 chk("R8 payload 0 pending", rd_empty, 1);
        tick;
        rd_req = 1'b0; rx_valid = 1'b1; rx_data = 8'h5A; tick;
        rx_valid = 1'b0;
        #1 chk("R8 payload 0 ready", rd_empty, 0);
        chk("R8 payload 0 data", rd_data, 8'h5A);
        rd_req = 1'b1; tick;
        #1 chk("R8 payload 1 pending", rd_empty, 1);
        rd_req = 1'b0; rx_valid = 1'b1; rx_data = 8'h5B; tick;
        rx_valid = 1'b0;
        #1 chk("R8 payload 1 data", rd_data, 8'h5B);
        rd_req = 1'b1; tick;
        #1 chk("R8 trailer pending", rd_empty, 1);
        rd_req = 1'b0; rx_end = 1'b1; rx_ed = 8'h11; rx_status = 8'h22; tick;
        rx_end = 1'b0;
        #1 chk("R8 closed frame not empty", rd_empty, 0);
        chk("R6 energy slot", rd_data, 8'h11);
        rd_req = 1'b1; tick;
        #1 chk("R6 status slot", rd_data, 8'h22);
        rd_req = 1'b0; rd_active = 1'b0; tick;
    endtask

    task automatic t_reptr;
        rd_active = 1'b1; rd_req = 1'b1; tick; tick;
        #1 chk("R6 pointer advanced", rd_data, 8'h5B);
        rd_active = 1'b0; rd_req = 1'b0; tick;
        #1 chk("R7 pointer reset idle", rd_data, 2);
        rd_active = 1'b1; #1;
        chk("R7 new access starts at length", rd_data, 2);
        tick; rd_active = 1'b0; tick;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ext_mode = 1'b0; rx_start = 1'b0; rx_valid = 1'b0;
        rx_data = '0; rx_end = 1'b0; rx_crc_ok = 1'b0; rx_irq_end = 1'b0;
        rx_ed = '0; rx_status = '0; rd_active = 1'b0; rd_req = 1'b0;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_basic_overwrite;
        t_basic_lock;
        t_ext;
        t_limit;
        t_empty;
        t_reptr;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule